// File: doc/BRIEF.md
# UART register and interrupt front end

This block is the software-visible face of a simple serial port. It sits on a 32-bit memory-mapped slave bus and holds six word registers: received byte, byte to send, status, control, baud divisor and packet-end match byte. The serial shift engines are outside the block. The receiver presents each finished byte as a one-cycle strobe with parity, framing and break flags. The transmitter tells the block when it takes the held byte and whether its shifter is idle.

The status register collects sticky error flags, the two ready bits, a transmit-empty bit, an exception summary, the synchronised clear-to-send level, a sticky flag that records a change of that level, and a packet-end flag. Each interrupt-enable bit in the control register sits at the same position as the status bit it enables. The single level interrupt is high whenever an enabled status bit is set. Two control bits that are not enables drive the request-to-send output and force a break on the line. The divisor register feeds the transmitter its bit-period count, which is the input clock frequency divided by the baud rate.

Top module: `uart_csr_unit`

## Requirements
- R1: After reset the control register reads 0, the divisor reads `DIV_RESET`, `irq`, `rts_out` and `brk_out` are 0, and the status reads 0x060 (tx ready bit 6 and tx empty bit 5 set) while `core_tx_idle` is high and `cts_in` is low.
- R2: Word registers sit at byte offsets 0 (received byte), 4 (byte to send), 8 (status), 12 (control, 13 bits), 16 (divisor) and 20 (packet-end byte); offsets 24 and 28 read as zero; address bits 1:0 are ignored.
- R3: `irq` is high exactly when status AND control AND 0x15FF is nonzero. Control bit 9 drives `brk_out` and bit 11 drives `rts_out`, and neither of them raises `irq`.
- R4: A `rx_valid` strobe stores `rx_byte`, sets rx ready (bit 7) and sets parity error (bit 0), framing error (bit 1) and break (bit 2) from the matching flags. A read of offset 0 returns the byte and clears rx ready.
- R5: A byte that arrives while rx ready is still set sets rx overrun (bit 3) and replaces the stored byte.
- R6: A write to offset 4 while tx ready is set loads `tx_byte`, clears tx ready and raises `tx_full` until a `core_tx_take` strobe. A write made while tx ready is clear is discarded and sets tx overrun (bit 4).
- R7: Status bit 5 (tx empty) is set exactly when tx ready is set and `core_tx_idle` is high.
- R8: Status bit 8 (exception) is set exactly when any of bits 0 to 4 is set.
- R9: Any write to offset 8 clears bits 0 to 4, 10 and 12, whatever the data, and leaves the ready bits unchanged.
- R10: `cts_in` passes through a two-flop synchroniser. Status bit 11 shows the synchronised level two clock edges after a change, and the same edge sets the sticky bit 10.
- R11: Status bit 12 is set when a received byte, or a held byte taken by the transmitter, equals the packet-end register.
- R12: `divisor_out` equals the divisor register, which a write to offset 16 loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address within the register window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects on offset 0) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| rx_valid | input | 1 | Receiver finished a byte |
| rx_byte | input | CHAR_W | Received byte |
| rx_perr | input | 1 | Parity error on that byte |
| rx_ferr | input | 1 | Framing error on that byte |
| rx_brk | input | 1 | Break detected |
| core_tx_take | input | 1 | Transmitter took the held byte |
| core_tx_idle | input | 1 | Transmit shifter idle |
| tx_byte | output | CHAR_W | Byte held for the transmitter |
| tx_full | output | 1 | Held byte is waiting for the transmitter |
| divisor_out | output | DIV_W | Bit-period count for the serial core |
| cts_in | input | 1 | Clear-to-send line, asynchronous |
| rts_out | output | 1 | Request-to-send line |
| brk_out | output | 1 | Force break on the transmit line |
| irq | output | 1 | Level interrupt |

## Verification
The bench goes after a second received byte before the first is read. A design that gets this wrong keeps the stale byte or misses the overrun bit. It also writes twice with no take in between. A wrong design would overwrite the byte already handed to the transmitter instead of flagging tx overrun. It raises clear-to-send while the request-to-send control bit is set, which catches an interrupt mask that lets bit 11 through. It also times the synchroniser edge by edge, which exposes a chain one flop short or long. Random sequences of control writes, received bytes, takes, status clears and level changes are compared against a model, which catches a clear that wipes a ready bit or a packet-end match that never fires.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;
   localparam int ST_W = 13;
   localparam int B_PERR = 0;
   localparam int B_FERR = 1;
   localparam int B_BRK  = 2;
   localparam int B_ROVR = 3;
   localparam int B_TOVR = 4;
   localparam int B_TEMP = 5;
   localparam int B_TRDY = 6;
   localparam int B_RRDY = 7;
   localparam int B_EXC  = 8;
   localparam int B_FBRK = 9;
   localparam int B_DCTS = 10;
   localparam int B_CTS  = 11;
   localparam int B_EOP  = 12;
   localparam int N_ERR  = 5;
   localparam logic [ST_W-1:0] IRQ_EN_MASK = 13'h15FF;

   typedef enum logic [2:0] {
      W_RXD = 3'd0,
      W_TXD = 3'd1,
      W_STA = 3'd2,
      W_CTL = 3'd3,
      W_DIV = 3'd4,
      W_EOP = 3'd5
   } word_sel_e;
endpackage

// File: rtl/uart_csr_sync.sv
module uart_csr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q,
   output logic q_next
);
   if (STAGES < 2) begin : g_bad_stages
      $error("uart_csr_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= 1'b0;
      else        chain_q[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[i] <= 1'b0;
         else        chain_q[i] <= chain_q[i-1];
      end
   end

   assign q      = chain_q[STAGES-1];
   assign q_next = chain_q[STAGES-2];
endmodule

// File: rtl/uart_csr_status.sv
module uart_csr_status
   import uart_csr_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rx_valid,
   input  logic            rx_perr,
   input  logic            rx_ferr,
   input  logic            rx_brk,
   input  logic            rx_eop_hit,
   input  logic            rx_read,
   input  logic            tx_wr,
   input  logic            tx_take,
   input  logic            tx_eop_hit,
   input  logic            tx_idle,
   input  logic            st_wr,
   input  logic            cts_lvl,
   input  logic            cts_edge,
   output logic [ST_W-1:0] status
);
   logic [N_ERR-1:0] err_q, err_set;
   logic rrdy_q, trdy_q, dcts_q, eop_q;

   assign err_set[B_PERR] = rx_valid & rx_perr;
   assign err_set[B_FERR] = rx_valid & rx_ferr;
   assign err_set[B_BRK]  = rx_valid & rx_brk;
   assign err_set[B_ROVR] = rx_valid & rrdy_q & ~rx_read;
   assign err_set[B_TOVR] = tx_wr & ~trdy_q;

   for (genvar e = 0; e < N_ERR; e++) begin : g_err
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          err_q[e] <= 1'b0;
         else if (err_set[e]) err_q[e] <= 1'b1;
         else if (st_wr)      err_q[e] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rrdy_q <= 1'b0;
         trdy_q <= 1'b1;
         dcts_q <= 1'b0;
         eop_q  <= 1'b0;
      end else begin
         if (rx_valid)     rrdy_q <= 1'b1;
         else if (rx_read) rrdy_q <= 1'b0;

         if (tx_wr && trdy_q) trdy_q <= 1'b0;
         else if (tx_take)    trdy_q <= 1'b1;

         if (cts_edge)   dcts_q <= 1'b1;
         else if (st_wr) dcts_q <= 1'b0;

         if ((rx_valid && rx_eop_hit) || (tx_take && !trdy_q && tx_eop_hit))
            eop_q <= 1'b1;
         else if (st_wr)
            eop_q <= 1'b0;
      end
   end

   always_comb begin
      status              = '0;
      status[N_ERR-1:0]   = err_q;
      status[B_TEMP]      = trdy_q & tx_idle;
      status[B_TRDY]      = trdy_q;
      status[B_RRDY]      = rrdy_q;
      status[B_EXC]       = |err_q;
      status[B_DCTS]      = dcts_q;
      status[B_CTS]       = cts_lvl;
      status[B_EOP]       = eop_q;
   end

   // R5
   rx_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rrdy_q && !rx_read) |=> status[B_ROVR]);
   // R4
   rrdy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_read && !rx_valid) |=> !status[B_RRDY]);
   // R6
   tx_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_wr && !status[B_TRDY]) |=> (status[B_TOVR] && !status[B_TRDY]));
   // R9
   err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr && !rx_valid && !tx_wr) |=> (status[4:0] == 5'd0));
   // R10
   dcts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cts_lvl != $past(cts_lvl)) |-> status[B_DCTS]);
endmodule

// File: rtl/uart_csr_unit.sv
module uart_csr_unit
   import uart_csr_pkg::*;
#(
   parameter int               ADDR_W      = 5,
   parameter int               DATA_W      = 32,
   parameter int               CHAR_W      = 8,
   parameter int               DIV_W       = 16,
   parameter logic [DIV_W-1:0] DIV_RESET   = 16'd434,
   parameter int               SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              rx_valid,
   input  logic [CHAR_W-1:0] rx_byte,
   input  logic              rx_perr,
   input  logic              rx_ferr,
   input  logic              rx_brk,
   input  logic              core_tx_take,
   input  logic              core_tx_idle,
   output logic [CHAR_W-1:0] tx_byte,
   output logic              tx_full,
   output logic [DIV_W-1:0]  divisor_out,
   input  logic              cts_in,
   output logic              rts_out,
   output logic              brk_out,
   output logic              irq
);
   localparam int WIN_BITS = 5;
   localparam int WORD_LSB = 2;

   if (ADDR_W < WIN_BITS) begin : g_bad_addr
      $error("uart_csr_unit: ADDR_W must cover the 32-byte window");
   end
   if (DATA_W < ST_W || DIV_W > DATA_W || CHAR_W > DATA_W) begin : g_bad_width
      $error("uart_csr_unit: DATA_W too narrow for the registers");
   end

   logic in_window;
   if (ADDR_W > WIN_BITS) begin : g_upper_dec
      assign in_window = (bus_addr[ADDR_W-1:WIN_BITS] == '0);
   end else begin : g_no_upper
      assign in_window = 1'b1;
   end

   word_sel_e word;
   assign word = word_sel_e'(bus_addr[WIN_BITS-1:WORD_LSB]);

   logic wr_tx, wr_st, wr_ct, wr_dv, wr_ep, rd_rx;
   assign wr_tx = bus_wr & in_window & (word == W_TXD);
   assign wr_st = bus_wr & in_window & (word == W_STA);
   assign wr_ct = bus_wr & in_window & (word == W_CTL);
   assign wr_dv = bus_wr & in_window & (word == W_DIV);
   assign wr_ep = bus_wr & in_window & (word == W_EOP);
   assign rd_rx = bus_rd & in_window & (word == W_RXD);

   logic [ST_W-1:0]   ctrl_q, status;
   logic [DIV_W-1:0]  div_q;
   logic [CHAR_W-1:0] eopv_q, rx_hold_q, tx_hold_q;
   logic              cts_lvl, cts_nxt;

   uart_csr_sync #(.STAGES(SYNC_STAGES)) u_cts_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (cts_in),
      .q     (cts_lvl),
      .q_next(cts_nxt)
   );

   uart_csr_status u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_valid  (rx_valid),
      .rx_perr   (rx_perr),
      .rx_ferr   (rx_ferr),
      .rx_brk    (rx_brk),
      .rx_eop_hit(rx_byte == eopv_q),
      .rx_read   (rd_rx),
      .tx_wr     (wr_tx),
      .tx_take   (core_tx_take),
      .tx_eop_hit(tx_hold_q == eopv_q),
      .tx_idle   (core_tx_idle),
      .st_wr     (wr_st),
      .cts_lvl   (cts_lvl),
      .cts_edge  (cts_nxt != cts_lvl),
      .status    (status)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         div_q     <= DIV_RESET;
         eopv_q    <= '0;
         rx_hold_q <= '0;
         tx_hold_q <= '0;
      end else begin
         if (wr_ct) ctrl_q <= bus_wdata[ST_W-1:0];
         if (wr_dv) div_q  <= bus_wdata[DIV_W-1:0];
         if (wr_ep) eopv_q <= bus_wdata[CHAR_W-1:0];
         if (rx_valid) rx_hold_q <= rx_byte;
         if (wr_tx && status[B_TRDY]) tx_hold_q <= bus_wdata[CHAR_W-1:0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (in_window) begin
         case (word)
            W_RXD:   bus_rdata[CHAR_W-1:0] = rx_hold_q;
            W_TXD:   bus_rdata[CHAR_W-1:0] = tx_hold_q;
            W_STA:   bus_rdata[ST_W-1:0]   = status;
            W_CTL:   bus_rdata[ST_W-1:0]   = ctrl_q;
            W_DIV:   bus_rdata[DIV_W-1:0]  = div_q;
            W_EOP:   bus_rdata[CHAR_W-1:0] = eopv_q;
            default: bus_rdata = '0;
         endcase
      end
   end

   assign tx_byte     = tx_hold_q;
   assign tx_full     = ~status[B_TRDY];
   assign divisor_out = div_q;
   assign rts_out     = ctrl_q[B_CTS];
   assign brk_out     = ctrl_q[B_FBRK];
   assign irq         = |(status & ctrl_q & IRQ_EN_MASK);

   // R3
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((ctrl_q & IRQ_EN_MASK) != '0));
   // R12
   div_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dv |=> (divisor_out == $past(bus_wdata[DIV_W-1:0])));
   // R6
   tx_hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_tx && tx_full) |=> $stable(tx_byte));
endmodule

// File: tb/tb_uart_csr_unit.sv
module tb_uart_csr_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic        rx_valid = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
   logic [7:0]  rx_byte = '0, tx_byte;
   logic        core_tx_take = 1'b0, core_tx_idle = 1'b1, tx_full;
   logic [15:0] divisor_out;
   logic        cts_in = 1'b0, rts_out, brk_out, irq;

   int errors = 0, checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   uart_csr_unit dut (.*);

   // bench model
   logic m_pe, m_fe, m_bk, m_ro, m_to, m_rr, m_tr, m_dc, m_ct, m_eo;
   logic [12:0] m_ctrl;
   logic [7:0]  m_rx, m_tx, m_ev;

   function automatic logic [12:0] exp_status();
      logic ex = m_pe | m_fe | m_bk | m_ro | m_to;
      return {m_eo, m_ct, m_dc, 1'b0, ex, m_rr, m_tr, m_tr & core_tx_idle,
              m_to, m_ro, m_bk, m_fe, m_pe};
   endfunction

   function automatic logic exp_irq();
      return |(exp_status() & m_ctrl & 13'h15FF);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bwrite(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bread(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic rx_push(input logic [7:0] b, input logic p, input logic f, input logic k);
      @(negedge clk);
      rx_valid = 1'b1; rx_byte = b; rx_perr = p; rx_ferr = f; rx_brk = k;
      @(negedge clk);
      rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0;
      if (m_rr) m_ro = 1'b1;
      if (b == m_ev) m_eo = 1'b1;
      m_rx = b; m_rr = 1'b1;
      m_pe |= p; m_fe |= f; m_bk |= k;
   endtask

   task automatic tx_take();
      @(negedge clk);
      core_tx_take = 1'b1;
      @(negedge clk);
      core_tx_take = 1'b0;
      if (!m_tr) begin
         if (m_tx == m_ev) m_eo = 1'b1;
         m_tr = 1'b1;
      end
   endtask

   task automatic tx_write(input logic [7:0] b);
      bwrite(5'd4, {24'd0, b});
      if (m_tr) begin m_tx = b; m_tr = 1'b0; end
      else m_to = 1'b1;
   endtask

   task automatic st_clear(input logic [31:0] d);
      bwrite(5'd8, d);
      {m_pe, m_fe, m_bk, m_ro, m_to, m_dc, m_eo} = '0;
   endtask

   task automatic set_cts(input logic v);
      @(negedge clk);
      cts_in = v;
      @(negedge clk);
      @(negedge clk);
      if (v != m_ct) m_dc = 1'b1;
      m_ct = v;
   endtask

   task automatic check_all(input string tag);
      logic [31:0] s;
      bread(5'd8, s);
      chk({tag, " status"}, s, {19'd0, exp_status()});
      chk({tag, " irq"}, {31'd0, irq}, {31'd0, exp_irq()});
      chk({tag, " tx_full/tx_byte"}, {23'd0, tx_full, tx_byte}, {23'd0, ~m_tr, m_tx});
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] d;
      void'($urandom(32'h5eed_0042));
      {m_pe, m_fe, m_bk, m_ro, m_to, m_dc, m_ct, m_eo, m_rr} = '0;
      m_tr = 1'b1; m_ctrl = '0; m_rx = '0; m_tx = '0; m_ev = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      @(negedge clk); #1;
      chk("R1 irq/rts/brk", {29'd0, irq, rts_out, brk_out}, 32'd0);
      chk("R1 divisor_out", {16'd0, divisor_out}, 32'd434);
      bread(5'd12, d); chk("R1 control", d, 32'd0);
      bread(5'd8, d);  chk("R1 status", d, 32'h60);

      // R2 unmapped offsets and byte-lane bits ignored
      bread(5'd24, d); chk("R2 offset 24", d, 32'd0);
      bread(5'd28, d); chk("R2 offset 28", d, 32'd0);
      bwrite(5'd21, 32'h0000_0003); m_ev = 8'h03;
      bread(5'd20, d); chk("R2 eop offset 20", d, 32'h03);

      // R12 divisor
      bwrite(5'd16, 32'h0000_1B2C);
      @(negedge clk);
      chk("R12 divisor_out", {16'd0, divisor_out}, 32'h1B2C);
      bread(5'd16, d); chk("R12 divisor readback", d, 32'h1B2C);

      // R4, R5 rx and overrun
      rx_push(8'hA5, 1'b0, 1'b0, 1'b0);
      check_all("R4 rx ready");
      rx_push(8'h5A, 1'b1, 1'b0, 1'b0);
      check_all("R5 overrun + R8 exception");
      bread(5'd0, d); m_rr = 1'b0;
      chk("R5 rx byte replaced", d, 32'h5A);
      check_all("R4 read clears rx ready");

      // R9 clear with arbitrary data
      rx_push(8'h11, 1'b0, 1'b1, 1'b1);
      st_clear(32'h0);
      check_all("R9 clear keeps rx ready");

      // R6 tx and overrun, R11 eop via tx
      tx_write(8'h03);
      tx_write(8'h22);
      check_all("R6 tx overrun discards");
      chk("R6 tx_byte kept", {24'd0, tx_byte}, 32'h03);
      tx_take();
      check_all("R11 eop on taken tx byte");

      // R7 tx empty follows idle
      core_tx_idle = 1'b0;
      check_all("R7 shifter busy");
      core_tx_idle = 1'b1;

      // R10 synchroniser timing
      st_clear(32'hFFFF_FFFF);
      @(negedge clk); cts_in = 1'b1;
      @(negedge clk); bus_addr = 5'd8; #1;
      chk("R10 level after one edge", {31'd0, bus_rdata[11]}, 32'd0);
      @(negedge clk); #1;
      chk("R10 level after two edges", {30'd0, bus_rdata[11:10]}, 32'd3);
      m_ct = 1'b1; m_dc = 1'b1;

      // R3 rts bit and cts level share bit 11 but never interrupt
      bwrite(5'd12, 32'h0000_0A00); m_ctrl = 13'h0A00;
      st_clear(32'd0);
      @(negedge clk); #1;
      chk("R3 rts/brk outputs", {30'd0, rts_out, brk_out}, 32'd3);
      chk("R3 bit 11 masked from irq", {31'd0, irq}, 32'd0);
      bread(5'd12, d); chk("R3 control readback", d, 32'h0A00);

      // random phase
      for (int i = 0; i < 400; i++) begin
         int op = $urandom % 8;
         case (op)
            0: begin
               logic [12:0] c = 13'($urandom);
               bwrite(5'd12, {19'd0, c}); m_ctrl = c;
               @(negedge clk);
               chk("R3 rts_out", {31'd0, rts_out}, {31'd0, c[11]});
               chk("R3 brk_out", {31'd0, brk_out}, {31'd0, c[9]});
            end
            1: rx_push(8'($urandom % 8), ($urandom % 4) == 0, ($urandom % 4) == 0,
                       ($urandom % 6) == 0);
            2: begin
               bread(5'd0, d);
               chk("R4 rx byte", d, {24'd0, m_rx});
               m_rr = 1'b0;
            end
            3: tx_write(8'($urandom % 8));
            4: tx_take();
            5: st_clear($urandom);
            6: set_cts(~m_ct);
            default: begin
               logic [7:0] e = 8'($urandom % 8);
               bwrite(5'd20, {24'd0, e}); m_ev = e;
            end
         endcase
         check_all("R8/R11 random");
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule